// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a small group of external interrupt lines and turns their activity into per-line interrupt requests. Each line has a two-bit sense mode that selects what counts as activity: the line being low, any change of level, a falling transition or a rising transition. Every line is brought into the clock domain through a two-flop synchronizer. Edges are found by comparing two successive synchronized samples, so they are seen on the system clock, not asynchronously.

In the three transition modes a detected event sets a sticky per-line flag. Software clears the flag by writing a one to its bit. In low-level mode no flag is kept: the request follows the synchronized line and lasts only while the line stays low. A request reaches the outputs only when the line's mask bit and the global enable input are both set. A small register port gives write and read access to the sense-mode register, the mask register and the flag register. A combined output reports whether any gated request is active.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the sense register, mask register and flags are all zero, and every request output is low.
- R2: The sense register is 8 bits at address 0. Line n uses bits [2n+1:2n], with the higher bit at the odd position. All 8 bits are written and read back unchanged. The mask register is at address 1 in bits [3:0]. The flags are at address 2 in bits [3:0]. Address 3 reads zero, and unused read bits are zero.
- R3: Sense code 00 (low level) requests while the synchronized line is low and stops when it goes high. This mode never sets a flag.
- R4: Sense code 01 sets the line's flag on any change between two consecutive samples.
- R5: Sense code 10 sets the flag on a high-to-low change between two consecutive samples.
- R6: Sense code 11 sets the flag on a low-to-high change between two consecutive samples.
- R7: A line's request output is high only when its mask bit and the global enable are both high.
- R8: Writing 1 to a bit at address 2 clears that flag, and writing 0 leaves it alone. If an event and a clear of the same flag happen in the same cycle, the flag ends up set. A flag drops only through such a write.
- R9: Latency is fixed. A low level shows on the request two clock edges after the line changes. A transition shows as a flag and request three edges after the change.
- R10: In transition modes, a pulse that spans one rising clock edge produces a flag.
- R11: A line that is already high when reset is released produces no event. The first sample after reset only primes the comparison.
- R12: While a line's mask bit is clear, events do not set its flag. Clearing the mask before changing the line's sense code therefore produces no request.
- R13: The combined request is high exactly when at least one per-line request is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pins_i | input | 4 | External interrupt lines, asynchronous |
| gie_i | input | 1 | Global interrupt enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 sense, 1 mask, 2 flags) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_req_o | output | 4 | Gated per-line interrupt requests |
| irq_any_o | output | 1 | OR of the gated per-line requests |

## Verification
The hardest cases to reach are those that depend on exact cycle alignment. One is a clear write landing in the same cycle as a new event on the flag it clears. Another is an event arriving within the first few cycles after reset. The bench reaches the first by counting clock edges from a line toggle, so that the clear write is active across the third edge. It reaches the second by holding all lines high through reset and writing the any-change mode and the mask in the first two cycles after release. A behavioural model built on a sample queue is compared with every output on every cycle, including a long pseudo-random stretch of line, enable and register activity.

// File: rtl/ext_irq_pkg.sv
// Package: shared types and register addresses for the external interrupt
// sense unit. Assumes a two-bit sense code per line.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam logic [1:0] ADDR_SENSE = 2'd0;
    localparam logic [1:0] ADDR_MASK  = 2'd1;
    localparam logic [1:0] ADDR_FLAG  = 2'd2;

endpackage

// File: rtl/ext_irq_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous lines.
// It also carries a valid bit down a chain of the same length, so the
// consumer knows when the synchronized output holds real samples after reset.
// Assumes: each bit is an independent level, so no bus coherency is needed.
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             vld_o
);

    logic [WIDTH-1:0] chain_q [STAGES];
    logic [STAGES-1:0] vld_q;

    // Shift the raw lines and the valid marker through the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            vld_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            vld_q <= {vld_q[STAGES-2:0], 1'b1};
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign vld_o  = vld_q[STAGES-1];

endmodule

// File: rtl/ext_irq_cfg.sv
// Module: configuration registers, holding the sense codes and the mask.
// It also produces the write-one-to-clear strobe for the flag register.
// Assumes: a single-cycle write strobe and that the sense field fits in DATA_W.
module ext_irq_cfg
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int DATA_W   = 8,
    localparam int SENSE_W = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [1:0]          addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [SENSE_W-1:0]  sense_o,
    output logic [NUM_PINS-1:0] mask_o,
    output logic [NUM_PINS-1:0] flag_clr_o
);

    logic [SENSE_W-1:0]  sense_q;
    logic [NUM_PINS-1:0] mask_q;

    // Load the sense and mask registers on a write to their address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else if (we_i) begin
            if (addr_i == ADDR_SENSE) sense_q <= wdata_i[SENSE_W-1:0];
            if (addr_i == ADDR_MASK)  mask_q  <= wdata_i[NUM_PINS-1:0];
        end
    end

    // Produce the per-line clear strobe from a write of ones to the flag address.
    always_comb begin
        flag_clr_o = '0;
        if (we_i && addr_i == ADDR_FLAG) flag_clr_o = wdata_i[NUM_PINS-1:0];
    end

    assign sense_o = sense_q;
    assign mask_o  = mask_q;

endmodule

// File: rtl/ext_irq_line.sv
// Module: event detection for one line. It keeps the previous synchronized
// sample and a sticky flag, and produces the raw (ungated) request.
// Assumes: the input sample is already synchronized. s_vld_i is high once
// that sample is real, and stays high until the next reset.
module ext_irq_line
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   s_i,
    input  logic   s_vld_i,
    input  sense_e mode_i,
    input  logic   mask_i,
    input  logic   clr_i,
    output logic   flag_o,
    output logic   raw_o
);

    logic prev_q;
    logic prev_vld_q;
    logic flag_q;
    logic evt;

    // Hold the previous sample; the first real sample only primes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q     <= 1'b0;
            prev_vld_q <= 1'b0;
        end else begin
            prev_q     <= s_i;
            prev_vld_q <= s_vld_i;
        end
    end

    // Decode the event for the selected transition mode.
    always_comb begin
        unique case (mode_i)
            SENSE_ANY:  evt = s_i ^ prev_q;
            SENSE_FALL: evt = prev_q & ~s_i;
            SENSE_RISE: evt = ~prev_q & s_i;
            default:    evt = 1'b0;
        endcase
    end

    // Sticky flag: a qualified event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (evt & prev_vld_q & mask_i) | (flag_q & ~clr_i);
    end

    assign flag_o = flag_q;
    assign raw_o  = (mode_i == SENSE_LOW) ? (s_vld_i & ~s_i) : flag_q;

endmodule

// File: rtl/ext_irq_sense.sv
// Module: top level of the external interrupt sense unit. It synchronizes the
// lines, runs one detector per line, gates the requests and serves register reads.
// Assumes: reg_rdata_o is combinational from reg_addr_i.
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] irq_pins_i,
    input  logic                gie_i,
    input  logic                reg_we_i,
    input  logic [1:0]          reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic [NUM_PINS-1:0] irq_req_o,
    output logic                irq_any_o
);

    localparam int SENSE_W = 2 * NUM_PINS;

    logic [NUM_PINS-1:0] pins_sync;
    logic                sync_vld;
    logic [SENSE_W-1:0]  sense_ctrl;
    logic [NUM_PINS-1:0] irq_mask;
    logic [NUM_PINS-1:0] flag_clr;
    logic [NUM_PINS-1:0] irq_flag;
    logic [NUM_PINS-1:0] raw_req;

    ext_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_pins_i),
        .sync_o  (pins_sync),
        .vld_o   (sync_vld)
    );

    ext_irq_cfg #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .sense_o    (sense_ctrl),
        .mask_o     (irq_mask),
        .flag_clr_o (flag_clr)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_line
        ext_irq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_i     (pins_sync[g]),
            .s_vld_i (sync_vld),
            .mode_i  (sense_e'(sense_ctrl[2*g +: 2])),
            .mask_i  (irq_mask[g]),
            .clr_i   (flag_clr[g]),
            .flag_o  (irq_flag[g]),
            .raw_o   (raw_req[g])
        );
    end

    // Gate each raw request with its mask bit and the global enable.
    always_comb begin
        irq_req_o = raw_req & irq_mask & {NUM_PINS{gie_i}};
        irq_any_o = |irq_req_o;
    end

    // Select read data by address, zero-extended.
    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_SENSE: reg_rdata_o[SENSE_W-1:0]  = sense_ctrl;
            ADDR_MASK:  reg_rdata_o[NUM_PINS-1:0] = irq_mask;
            ADDR_FLAG:  reg_rdata_o[NUM_PINS-1:0] = irq_flag;
            default:    reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ext_irq_sense_chk.sv
// Module: assertion checker bound to ext_irq_sense. It watches the ports and
// the mask, flag and sense state. Assumes line 0 is representative for the
// per-line flag properties.
module ext_irq_sense_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  gie_i,
    input logic                  reg_we_i,
    input logic [1:0]            reg_addr_i,
    input logic [NUM_PINS-1:0]   irq_req_o,
    input logic                  irq_any_o,
    input logic [NUM_PINS-1:0]   irq_mask,
    input logic [NUM_PINS-1:0]   irq_flag,
    input logic [2*NUM_PINS-1:0] sense_ctrl
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_flag == '0 && irq_mask == '0 && sense_ctrl == '0));

    p_level_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_ctrl[1:0] == 2'b00 && !irq_flag[0]) |=> !irq_flag[0]);

    p_req_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o & ~irq_mask) == '0);

    p_any_needs_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o |-> gie_i);

    p_flag_drop_by_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we_i && reg_addr_i == ext_irq_pkg::ADDR_FLAG) |=> (($past(irq_flag) & ~irq_flag) == '0));

    p_masked_no_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mask[0] && !irq_flag[0]) |=> !irq_flag[0]);

    p_any_has_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any_o |-> ($countones(irq_req_o) > 0));

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie_i      (gie_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .irq_req_o  (irq_req_o),
    .irq_any_o  (irq_any_o),
    .irq_mask   (irq_mask),
    .irq_flag   (irq_flag),
    .sense_ctrl (sense_ctrl)
);

// File: tb/ext_irq_sense_tb.sv
// Testbench: a behavioural model built on a queue of samples, compared with
// every output at each falling edge. Inputs are driven just after the falling edge.
module ext_irq_sense_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'hF;
    logic       gie = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] req;
    logic       any;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string phase = "R1 reset state";

    ext_irq_sense u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pins_i  (pins),
        .gie_i       (gie),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_req_o   (req),
        .irq_any_o   (any)
    );

    always #2.5 clk = ~clk;

    // Reference model state.
    logic [3:0] samp[$];
    logic [7:0] m_sense = 8'h00;
    logic [3:0] m_mask = 4'h0;
    logic [3:0] m_flag = 4'h0;
    logic [3:0] m_set, m_clr, m_s, m_p;
    logic [1:0] m_mode;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            samp.delete();
            m_sense = 8'h00; m_mask = 4'h0; m_flag = 4'h0;
        end else begin
            m_set = 4'h0;
            if (samp.size() >= 3) begin
                m_s = samp[samp.size()-2];
                m_p = samp[samp.size()-3];
                for (int i = 0; i < 4; i++) begin
                    m_mode = m_sense[2*i +: 2];
                    if (m_mode == 2'b01) m_set[i] = m_s[i] != m_p[i];
                    if (m_mode == 2'b10) m_set[i] = m_p[i] && !m_s[i];
                    if (m_mode == 2'b11) m_set[i] = !m_p[i] && m_s[i];
                    m_set[i] = m_set[i] & m_mask[i];
                end
            end
            m_clr  = (we && addr == 2'd2) ? wdata[3:0] : 4'h0;
            m_flag = m_set | (m_flag & ~m_clr);
            if (we && addr == 2'd0) m_sense = wdata;
            if (we && addr == 2'd1) m_mask = wdata[3:0];
            samp.push_back(pins);
            if (samp.size() > 4) void'(samp.pop_front());
        end
    end

    function automatic logic [3:0] exp_req();
        logic [3:0] r = 4'h0;
        for (int i = 0; i < 4; i++) begin
            if (m_sense[2*i +: 2] == 2'b00)
                r[i] = (samp.size() >= 2) && !samp[samp.size()-2][i];
            else
                r[i] = m_flag[i];
        end
        return r & m_mask & {4{gie}};
    endfunction

    function automatic logic [7:0] exp_rdata();
        case (addr)
            2'd0:    return m_sense;
            2'd1:    return {4'h0, m_mask};
            2'd2:    return {4'h0, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge (R13 for the combined request).
    always @(negedge clk) begin
        logic [3:0] er;
        er = exp_req();
        chk(req === er, {phase, " req"}, {4'h0, req}, {4'h0, er});
        chk(any === (er != 4'h0), {phase, " R13 any"}, {7'h0, any}, {7'h0, (er != 4'h0)});
        chk(rdata === exp_rdata(), {phase, " rdata"}, rdata, exp_rdata());
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        tick();
        we = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        wait (cycles >= 20000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with all lines high; R11 follows at release.
        tick(3);
        addr = 2'd0; tick();
        chk(rdata == 8'h00, "R1 sense reset", rdata, 8'h00);
        addr = 2'd1; tick();
        chk(rdata == 8'h00, "R1 mask reset", rdata, 8'h00);
        addr = 2'd2; tick();
        chk(req == 4'h0, "R1 req reset", {4'h0, req}, 8'h00);

        // R11: release reset and arm any-change mode at once; lines stay high.
        phase = "R11 no event after reset";
        gie = 1'b1;
        rst_n = 1'b1;
        wr(2'd0, 8'h55);
        wr(2'd1, 8'h0F);
        addr = 2'd2;
        tick(6);
        chk(rdata[3:0] == 4'h0, "R11 flags stay clear", rdata, 8'h00);

        // R2: sense register layout and readback.
        phase = "R2 register readback";
        wr(2'd0, 8'hA5);
        addr = 2'd0; tick();
        chk(rdata == 8'hA5, "R2 sense readback", rdata, 8'hA5);
        addr = 2'd3; tick();
        chk(rdata == 8'h00, "R2 unused address", rdata, 8'h00);

        // Modes: line0 any, line1 fall, line2 rise, line3 rise.
        phase = "R4 R5 R6 transition modes";
        wr(2'd0, 8'b11_11_10_01);
        addr = 2'd2;
        pins = 4'hF; tick(4);
        wr(2'd2, 8'h0F); tick(2);
        pins = 4'b0000; tick(4);
        chk(rdata[3:0] == 4'b0011, "R5 fall sets line1, R4 any sets line0", rdata, 8'h03);
        wr(2'd2, 8'h0F); tick(2);
        pins = 4'b0101;
        tick(2);
        chk(req == 4'h0, "R9 no flag two edges after change", {4'h0, req}, 8'h00);
        tick();
        chk(req == 4'b0101, "R9 R6 R4 flag on third edge", {4'h0, req}, 8'h05);

        // R7: global enable and mask gating.
        phase = "R7 gating";
        gie = 1'b0; tick();
        chk(req == 4'h0, "R7 global enable off", {4'h0, req}, 8'h00);
        gie = 1'b1; wr(2'd1, 8'h01); tick();
        chk(req == 4'b0001, "R7 mask gates line2", {4'h0, req}, 8'h01);
        wr(2'd1, 8'h0F);

        // R8: W1C, with set winning over a same-cycle clear.
        phase = "R8 clear";
        wr(2'd2, 8'h04); tick();
        chk(rdata[3:0] == 4'b0001, "R8 write-one clears only line2", rdata, 8'h01);
        wr(2'd2, 8'h0F); tick(2);
        pins[0] = ~pins[0];
        tick(2);
        we = 1'b1; addr = 2'd2; wdata = 8'h01;
        tick();
        we = 1'b0;
        chk(rdata[0] == 1'b1, "R8 set wins over clear", rdata, 8'h01);
        wr(2'd2, 8'h0F);

        // R10: one-cycle pulse on line3 (rise mode).
        phase = "R10 short pulse";
        pins[3] = 1'b0; tick(4);
        wr(2'd2, 8'h08);
        pins[3] = 1'b1; tick();
        pins[3] = 1'b0; tick(4);
        chk(rdata[3] == 1'b1, "R10 pulse caught", rdata, 8'h08);
        wr(2'd2, 8'h0F);

        // R3: level mode on line0.
        phase = "R3 low level";
        wr(2'd0, 8'b11_11_10_00);
        pins[0] = 1'b1; tick(3);
        pins[0] = 1'b0; tick();
        chk(req[0] == 1'b0, "R9 level not yet after one edge", {7'h0, req[0]}, 8'h00);
        tick();
        chk(req[0] == 1'b1, "R3 level request while low", {7'h0, req[0]}, 8'h01);
        tick(4);
        chk(rdata[0] == 1'b0, "R3 no flag in level mode", rdata, 8'h00);
        pins[0] = 1'b1; tick(2);
        chk(req[0] == 1'b0, "R3 drops when high", {7'h0, req[0]}, 8'h00);

        // R12: mask cleared before mode change; masked events are dropped.
        phase = "R12 masked mode change";
        pins[1] = 1'b0; tick(4);
        wr(2'd2, 8'h0F);
        wr(2'd1, 8'b1101);
        wr(2'd0, 8'b11_11_00_00);
        tick(2);
        chk(req[1] == 1'b0, "R12 no request with mask cleared", {7'h0, req[1]}, 8'h00);
        wr(2'd0, 8'b11_11_01_00);
        pins[1] = 1'b1; tick(4);
        chk(rdata[1] == 1'b0, "R12 masked event not latched", rdata, 8'h00);
        wr(2'd1, 8'h0F); tick();
        chk(req[1] == 1'b0, "R12 no request after unmask", {7'h0, req[1]}, 8'h00);

        // Pseudo-random stretch, all requirements via the per-cycle model compare.
        phase = "R4 R5 R6 R7 R8 random";
        for (int n = 0; n < 600; n++) begin
            pins = 4'($urandom);
            gie  = ($urandom % 8) != 0;
            if (($urandom % 6) == 0) begin
                we = 1'b1;
                addr = 2'($urandom);
                wdata = 8'($urandom);
            end else begin
                we = 1'b0;
                addr = 2'($urandom);
            end
            tick();
        end
        we = 1'b0;
        tick(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule